// File: doc/BRIEF.md
# Capture/Compare Timer with Two-Step Flag Clearing

A 16-bit up-counter peripheral reached over an 8-bit register bus. The counter can be stopped, advanced on every clock, advanced on every eighth clock, or advanced by a selected transition on an external clock pin. Around it sit one capture register, which takes the counter value on a chosen edge of the capture pin, and two compare registers. The first compare register raises a compare flag. The second is used only in PWM mode, where reaching it raises the capture flag in place of the pin.

There are three flags: capture, compare and overflow. Each one is cleared by a fixed two-step sequence. Software first reads the status register while the flag is set, and then reads or writes the low byte of the data register that belongs to that flag. If a fresh event arrives between the two steps, the pending clear is cancelled, so that new event is not lost. A read of a high byte stores the matching low byte, so a 16-bit value can be read coherently in two bus accesses. Each flag, ANDed with its enable bit, drives its own interrupt request.

Top module: `capcmp_timer`

## Requirements
- R1: After synchronous reset, status (address 1) and control (address 0) read 00h, all three interrupt outputs are low, and both compare registers read FFFFh.
- R2: Status bit 7 is the capture flag, bit 6 the compare flag and bit 5 the overflow flag; bits 4..0 read 0. Bus writes to status or to the counter addresses (2..5) change nothing.
- R3: Control bits [3:2] pick the counter clock: 00 holds, 01 advances every clock, 10 advances once per 8 clocks, 11 advances on external-pin edges. The live counter reads at address 4 (high) and 5 (low).
- R4: Control bit 0 picks the counting transition of the external pin (1 rising, 0 falling). When the block is built without an external clock pin, code 11 holds the counter.
- R5: The overflow flag sets when the counter advances from FFFFh to 0000h.
- R6: The compare flag sets when the counter advances onto the value of compare register 1 (high byte at address 8, low byte at address 9).
- R7: Outside PWM mode, the capture-pin edge selected by control bit 1 (1 rising, 0 falling) copies the counter into the capture register (addresses 6/7) and sets the capture flag. The opposite edge has no effect.
- R8: With control bit 4 set (PWM mode), the capture flag sets when the counter advances onto compare register 2 (addresses 10/11). The capture pin is ignored in this mode.
- R9: A flag clears only if a status read made while the flag was set is followed by a read or write of its own low byte: address 3 (overflow), 9 (compare) or 7 (capture). Without that status read the access does not clear the flag, and address 5 never clears overflow.
- R10: A new event on a flag between its status read and its low-byte access cancels the pending clear.
- R11: A read of address 2 or address 6 stores the current low byte of the counter or capture register. Addresses 3 and 7 then return that stored byte.
- R12: The capture, compare and overflow interrupt outputs equal their flags gated by control bits 7, 6 and 5 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ext_clk_pin | input | 1 | External counter clock pin |
| cap_pin | input | 1 | Capture input pin |
| irq_cap | output | 1 | Capture / period-match interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is an event that lands between the status read and the clearing low-byte access (R10). The bench counts with the external pin, so the counter moves exactly once per pulse. It arms the compare flag with a status read, moves the counter by one edge onto a compare value written earlier, and only then issues the clearing access. Writing the compare low byte is itself a clearing access, so the compare value must be placed before the status read and never rewritten between the two steps.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int N_FLG  = 3;

    // flag vector index; status bits [7:5] = flag vector [2:0]
    localparam int FLG_OVF = 0;
    localparam int FLG_CMP = 1;
    localparam int FLG_CAP = 2;

    typedef enum logic [3:0] {
        A_CTRL    = 4'd0,
        A_STAT    = 4'd1,
        A_CNT_HI  = 4'd2,
        A_CNT_LO  = 4'd3,
        A_LIVE_HI = 4'd4,
        A_LIVE_LO = 4'd5,
        A_CAP_HI  = 4'd6,
        A_CAP_LO  = 4'd7,
        A_CMP1_HI = 4'd8,
        A_CMP1_LO = 4'd9,
        A_CMP2_HI = 4'd10,
        A_CMP2_LO = 4'd11
    } reg_addr_e;

    typedef enum logic [1:0] {
        CS_HOLD = 2'b00,
        CS_CPU  = 2'b01,
        CS_DIV  = 2'b10,
        CS_EXT  = 2'b11
    } clk_sel_e;

    typedef struct packed {
        logic     cap_ie;
        logic     cmp_ie;
        logic     ovf_ie;
        logic     pwm;
        clk_sel_e csel;
        logic     cap_rise;
        logic     ext_rise;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] hi_byte(input logic [CNT_W-1:0] v);
        return v[CNT_W-1:BYTE_W];
    endfunction

    function automatic logic [BYTE_W-1:0] lo_byte(input logic [CNT_W-1:0] v);
        return v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/capcmp_edge_sync.sv
module capcmp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_stb
);
    logic [STAGES-1:0] sr_q;
    logic              prev_q;
    logic              cur;

    assign cur = sr_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sr_q   <= {sr_q[STAGES-2:0], pin};
            prev_q <= cur;
        end
    end

    always_comb begin
        if (rise_sel) edge_stb = cur & ~prev_q;
        else          edge_stb = ~cur & prev_q;
    end
endmodule

// File: rtl/capcmp_prescale.sv
module capcmp_prescale #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/capcmp_flag.sv
module capcmp_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic stat_rd,
    input  logic clr_acc,
    output logic flag_q,
    output logic arm_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else if (set_ev) begin
            flag_q <= 1'b1;
            arm_q  <= 1'b0;
        end else if (clr_acc && arm_q) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else if (stat_rd && flag_q) begin
            arm_q  <= 1'b1;
        end
    end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
    import capcmp_pkg::*;
#(
    parameter int PRESCALE_DIV = 8,
    parameter int SYNC_STAGES  = 2,
    parameter bit HAS_EXT_CLK  = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ext_clk_pin,
    input  logic       cap_pin,
    output logic       irq_cap,
    output logic       irq_cmp,
    output logic       irq_ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt, cap_q, cmp1_q, cmp2_q;
    logic [BYTE_W-1:0] cnt_lo_lat, cap_lo_lat;
    logic              div_tick, ext_stb, cap_edge, cap_stb, cnt_tick;
    logic              bus_acc, stat_rd;
    logic [N_FLG-1:0]  set_ev, clr_acc, flag_q, arm_q, flag_ie;
    reg_addr_e         addr;

    assign addr    = reg_addr_e'(bus_addr);
    assign bus_acc = bus_rd | bus_wr;
    assign stat_rd = bus_rd && (addr == A_STAT);

    // clock sources
    capcmp_prescale #(.DIV(PRESCALE_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (div_tick)
    );

    generate
        if (HAS_EXT_CLK) begin : g_ext
            capcmp_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
                .clk      (clk),
                .rst      (rst),
                .pin      (ext_clk_pin),
                .rise_sel (ctrl_q.ext_rise),
                .edge_stb (ext_stb)
            );
        end else begin : g_noext
            assign ext_stb = 1'b0;
        end
    endgenerate

    capcmp_edge_sync #(.STAGES(SYNC_STAGES)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .pin      (cap_pin),
        .rise_sel (ctrl_q.cap_rise),
        .edge_stb (cap_edge)
    );

    always_comb begin
        unique case (ctrl_q.csel)
            CS_HOLD: cnt_tick = 1'b0;
            CS_CPU:  cnt_tick = 1'b1;
            CS_DIV:  cnt_tick = div_tick;
            default: cnt_tick = ext_stb;
        endcase
    end

    assign cnt_nxt = cnt_q + 16'd1;
    assign cap_stb = cap_edge & ~ctrl_q.pwm;

    // events
    assign set_ev[FLG_OVF] = cnt_tick && (cnt_q == CNT_MAX);
    assign set_ev[FLG_CMP] = cnt_tick && (cnt_nxt == cmp1_q);
    assign set_ev[FLG_CAP] = cap_stb ||
                             (ctrl_q.pwm && cnt_tick && (cnt_nxt == cmp2_q));

    assign clr_acc[FLG_OVF] = bus_acc && (addr == A_CNT_LO);
    assign clr_acc[FLG_CMP] = bus_acc && (addr == A_CMP1_LO);
    assign clr_acc[FLG_CAP] = bus_acc && (addr == A_CAP_LO);

    assign flag_ie = {ctrl_q.cap_ie, ctrl_q.cmp_ie, ctrl_q.ovf_ie};

    generate
        for (genvar i = 0; i < N_FLG; i++) begin : g_flag
            capcmp_flag u_flag (
                .clk     (clk),
                .rst     (rst),
                .set_ev  (set_ev[i]),
                .stat_rd (stat_rd),
                .clr_acc (clr_acc[i]),
                .flag_q  (flag_q[i]),
                .arm_q   (arm_q[i])
            );
        end
    endgenerate

    assign irq_cap = flag_q[FLG_CAP] & flag_ie[FLG_CAP];
    assign irq_cmp = flag_q[FLG_CMP] & flag_ie[FLG_CMP];
    assign irq_ovf = flag_q[FLG_OVF] & flag_ie[FLG_OVF];

    // counter and capture
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cap_q <= '0;
        end else begin
            if (cnt_tick) cnt_q <= cnt_nxt;
            if (cap_stb)  cap_q <= cnt_q;
        end
    end

    // writable registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp1_q <= '1;
            cmp2_q <= '1;
        end else if (bus_wr) begin
            unique case (addr)
                A_CTRL:    ctrl_q <= ctrl_t'(bus_wdata);
                A_CMP1_HI: cmp1_q[CNT_W-1:BYTE_W] <= bus_wdata;
                A_CMP1_LO: cmp1_q[BYTE_W-1:0]     <= bus_wdata;
                A_CMP2_HI: cmp2_q[CNT_W-1:BYTE_W] <= bus_wdata;
                A_CMP2_LO: cmp2_q[BYTE_W-1:0]     <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // coherent low-byte latches
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_lo_lat <= '0;
            cap_lo_lat <= '0;
        end else if (bus_rd) begin
            if (addr == A_CNT_HI) cnt_lo_lat <= lo_byte(cnt_q);
            if (addr == A_CAP_HI) cap_lo_lat <= lo_byte(cap_q);
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:    bus_rdata = ctrl_q;
            A_STAT:    bus_rdata = {flag_q, 5'b0};
            A_CNT_HI:  bus_rdata = hi_byte(cnt_q);
            A_CNT_LO:  bus_rdata = cnt_lo_lat;
            A_LIVE_HI: bus_rdata = hi_byte(cnt_q);
            A_LIVE_LO: bus_rdata = lo_byte(cnt_q);
            A_CAP_HI:  bus_rdata = hi_byte(cap_q);
            A_CAP_LO:  bus_rdata = cap_lo_lat;
            A_CMP1_HI: bus_rdata = hi_byte(cmp1_q);
            A_CMP1_LO: bus_rdata = lo_byte(cmp1_q);
            A_CMP2_HI: bus_rdata = hi_byte(cmp2_q);
            A_CMP2_LO: bus_rdata = lo_byte(cmp2_q);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        cnt_tick,
    input logic [15:0] cnt_q,
    input logic [15:0] cap_q,
    input logic        cap_stb,
    input logic [2:0]  flags,
    input logic [2:0]  arms,
    input logic [2:0]  set_ev
);
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cnt_tick |=> $stable(cnt_q)); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        cnt_tick |=> cnt_q == $past(cnt_q) + 16'd1); // R3
    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (cnt_tick && cnt_q == 16'hFFFF) |=> flags[0]); // R5
    AST_CAP_LATCH: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> cap_q == $past(cnt_q)); // R7
    AST_OVF_NO_UNARMED_CLR: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !arms[0]) |=> flags[0]); // R9
    AST_CMP_NO_UNARMED_CLR: assert property (@(posedge clk) disable iff (rst)
        (flags[1] && !arms[1]) |=> flags[1]); // R9
    AST_CAP_NO_UNARMED_CLR: assert property (@(posedge clk) disable iff (rst)
        (flags[2] && !arms[2]) |=> flags[2]); // R9
    AST_EVENT_DISARMS: assert property (@(posedge clk) disable iff (rst)
        set_ev[1] |=> (flags[1] && !arms[1])); // R10
endmodule

bind capcmp_timer capcmp_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_tick (cnt_tick),
    .cnt_q    (cnt_q),
    .cap_q    (cap_q),
    .cap_stb  (cap_stb),
    .flags    (flag_q),
    .arms     (arm_q),
    .set_ev   (set_ev)
);

// File: tb/capcmp_timer_test.sv
module capcmp_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, nx_rdata;
    logic       ext_clk_pin = 1'b0, cap_pin = 1'b0;
    logic       irq_cap, irq_cmp, irq_ovf;
    logic       nx_cap, nx_cmp, nx_ovf;

    int total = 0;
    int bad   = 0;
    logic [7:0] rv, rv2, nx_last;

    always #5 clk = ~clk;

    capcmp_timer uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_pin(ext_clk_pin),
        .cap_pin(cap_pin), .irq_cap(irq_cap), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
    );

    capcmp_timer #(.HAS_EXT_CLK(1'b0)) uut_nx (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(nx_rdata), .ext_clk_pin(ext_clk_pin),
        .cap_pin(cap_pin), .irq_cap(nx_cap), .irq_cmp(nx_cmp), .irq_ovf(nx_ovf)
    );

    // {addr, write data, expected read-back}
    localparam logic [19:0] VEC [0:7] = '{
        20'h0E3E3, 20'h81212, 20'h93434, 20'hA5656,
        20'hB7878, 20'h1FF00, 20'h2AA00, 20'h00000
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata; nx_last = nx_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ext_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_pin = 1'b1; repeat (4) @(negedge clk);
            ext_clk_pin = 1'b0; repeat (4) @(negedge clk);
        end
    endtask

    task automatic set_cap(input logic v);
        cap_pin = v; repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(4'd1, rv); check("R1 status", rv, 8'h00);
        rd(4'd0, rv); check("R1 control", rv, 8'h00);
        check("R1 irqs", {irq_cap, irq_cmp, irq_ovf}, 3'b000);
        rd(4'd8, rv); rd(4'd9, rv2); check("R1 cmp1", {rv, rv2}, 16'hFFFF);
        rd(4'd10, rv); rd(4'd11, rv2); check("R1 cmp2", {rv, rv2}, 16'hFFFF);

        // R2 register vectors (status/counter writes ignored)
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][19:16], VEC[i][15:8]);
            rd(VEC[i][19:16], rv);
            check("R2 vector", rv, {8'h00, VEC[i][7:0]});
        end

        // R3/R4 external rising then falling
        wr(4'd0, 8'h0D);
        ext_pulse(5);
        rd(4'd5, rv); check("R4 rising count", rv, 8'd5);
        check("R4 no ext pin holds", nx_last, 8'd0);
        wr(4'd0, 8'h0C);
        ext_pulse(3);
        rd(4'd4, rv); rd(4'd5, rv2); check("R4 falling count", {rv, rv2}, 16'd8);

        // R11 coherent low byte
        rd(4'd2, rv);
        wr(4'd0, 8'h0D);
        ext_pulse(1);
        rd(4'd3, rv); check("R11 latched low", rv, 8'd8);
        rd(4'd5, rv); check("R11 live low", rv, 8'd9);

        // R3 divide by 8: exactly 80 counting edges
        wr(4'd0, 8'h08);
        repeat (78) @(negedge clk);
        wr(4'd0, 8'h00);
        rd(4'd5, rv); check("R3 div8", rv, 8'd19);
        repeat (20) @(negedge clk);
        rd(4'd5, rv); check("R3 hold", rv, 8'd19);

        // R6/R9/R10/R12 compare
        wr(4'd0, 8'h4D);
        wr(4'd8, 8'h00); wr(4'd9, 8'h16);
        ext_pulse(2);
        rd(4'd1, rv); check("R6 before match", rv, 8'h00);
        ext_pulse(1);
        check("R12 irq_cmp", {irq_cap, irq_cmp, irq_ovf}, 3'b010);
        wr(4'd9, 8'h17);
        rd(4'd1, rv); check("R9 no clear without status read", rv, 8'h40);
        ext_pulse(1);
        wr(4'd9, 8'h17);
        rd(4'd1, rv); check("R10 new event cancels clear", rv, 8'h40);
        rd(4'd9, rv);
        rd(4'd1, rv); check("R9 compare cleared", rv, 8'h00);
        check("R12 irq_cmp low", irq_cmp, 1'b0);

        // R7 capture
        wr(4'd0, 8'h82);
        set_cap(1'b1);
        rd(4'd1, rv); check("R7 capture flag", rv, 8'h80);
        check("R12 irq_cap", irq_cap, 1'b1);
        rd(4'd6, rv); rd(4'd7, rv2); check("R7 capture value", {rv, rv2}, 16'h0017);
        rd(4'd1, rv); check("R9 capture cleared", rv, 8'h00);
        wr(4'd0, 8'h8F);
        ext_pulse(1);
        wr(4'd0, 8'h82);
        set_cap(1'b0);
        rd(4'd1, rv); check("R7 opposite edge flag", rv, 8'h00);
        rd(4'd6, rv); rd(4'd7, rv2); check("R7 opposite edge value", {rv, rv2}, 16'h0017);
        wr(4'd0, 8'h80);
        set_cap(1'b1);
        set_cap(1'b0);
        rd(4'd1, rv); rd(4'd6, rv); rd(4'd7, rv2);
        check("R7 falling capture", {rv, rv2}, 16'h0018);
        rd(4'd1, rv); rd(4'd7, rv);
        rd(4'd1, rv); check("R9 capture cleared again", rv, 8'h00);

        // R8 PWM mode
        wr(4'd0, 8'h1F);
        wr(4'd10, 8'h00); wr(4'd11, 8'h1A);
        set_cap(1'b1);
        rd(4'd1, rv); check("R8 pin ignored flag", rv, 8'h00);
        rd(4'd6, rv); rd(4'd7, rv2); check("R8 pin ignored value", {rv, rv2}, 16'h0018);
        ext_pulse(1);
        rd(4'd1, rv); check("R8 before period match", rv, 8'h00);
        ext_pulse(1);
        rd(4'd1, rv); check("R8 period match", rv, 8'h80);
        rd(4'd7, rv);
        rd(4'd1, rv); check("R8 cleared", rv, 8'h00);
        set_cap(1'b0);

        // R5 overflow and R9 alternate low byte
        wr(4'd0, 8'h24);
        repeat (65530) @(negedge clk);
        wr(4'd0, 8'h20);
        rd(4'd1, rv); check("R5 overflow flag", rv & 8'hA0, 8'h20);
        check("R12 irq_ovf", irq_ovf, 1'b1);
        rd(4'd5, rv);
        rd(4'd1, rv); check("R9 live low keeps overflow", rv & 8'h20, 8'h20);
        rd(4'd3, rv);
        rd(4'd1, rv); check("R9 overflow cleared", rv & 8'h20, 8'h00);
        check("R12 irq_ovf low", irq_ovf, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule